// File: doc/BRIEF.md
# Serial Keyboard Byte Receiver

This block takes bytes from a keyboard that shares a two-wire clock/data link with the host. Both wires come in through two-flop synchronizers. The keyboard moves the data line while its clock is high, and the receiver captures one bit on each falling edge of the synchronized clock. A character is eleven bits long. It opens with a low start bit, carries eight data bits with bit 0 sent first, then an odd-parity bit, and closes with a high stop bit.

A complete character goes into a single-byte holding register. From that point the receiver pulls the keyboard clock low through an open-drain enable, so the keyboard cannot send again until the host takes the byte. When parity fails for the first time, the block raises a one-cycle resend request towards the transmit side and waits for the repeat. When the repeat also fails, or when a character is late or badly framed, the holding register gets FFh and an error flag is set.

The frame timeout is counted in system clock cycles: `MS_CYCLES` cycles per millisecond times `FRAME_MS` milliseconds.

Top module: `kbd_rx_engine`

## Requirements
- R1: After reset, rx_valid, kbd_clk_oe, err_parity, err_timeout and resend_req are all 0.
- R2: A well-formed character (start 0, data bit 0 first through bit 7, parity making the nine data+parity bits hold an odd number of ones, stop 1) is delivered as rx_byte equal to its eight data bits, with both error flags 0.
- R3: While rx_valid is 1, kbd_clk_oe is 1 (the clock line is driven low). One cycle after buf_take is sampled high with rx_valid 1, both return to 0.
- R4: The first character with bad parity produces exactly one single-cycle resend_req pulse and no delivery. A good repeat then delivers its byte with both flags 0.
- R5: Two consecutive characters with bad parity deliver rx_byte = FFh with err_parity = 1 and err_timeout = 0, and produce only one resend_req pulse.
- R6: If a character has not completed within MS_CYCLES*FRAME_MS cycles after its start bit is recognised, FFh is delivered with err_timeout = 1 and err_parity = 0.
- R7: A character whose stop bit samples low delivers FFh with err_timeout = 1.
- R8: buf_take while rx_valid is 0 changes nothing, and a falling clock edge with data high while idle does not start a character.
- R9: rx_valid rises on the third rising system-clock edge after the final falling keyboard-clock edge reaches the input, and not on the second.
- R10: The next clean delivery after an error clears both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kbd_clk_i | input | 1 | Keyboard clock line as seen at the pad |
| kbd_dat_i | input | 1 | Keyboard data line as seen at the pad |
| kbd_clk_oe | output | 1 | 1 drives the keyboard clock line low (open-drain enable) |
| buf_take | input | 1 | Host read strobe that empties the holding register |
| rx_byte | output | 8 | Received byte, or FFh after an error |
| rx_valid | output | 1 | Holding register full |
| err_parity | output | 1 | Repeated character failed parity |
| err_timeout | output | 1 | Character timed out or had a low stop bit |
| resend_req | output | 1 | One-cycle request that the keyboard resend |

## Verification
A delivery shows up three system cycles after the last falling keyboard edge is driven: two cycles of synchronizer and one of state register. For that reason the bench samples rx_valid once after two edges, expecting 0, and once after three, expecting 1. The same three-cycle path sets the time of the resend pulse, which the bench counts on every falling system edge instead of catching in one fixed cycle. The release of the clock is due one cycle after buf_take and is checked at the very next falling edge. The timeout is checked well past MS_CYCLES*FRAME_MS cycles after the truncated character stops, so that exact timer alignment does not matter.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;
  localparam int DATA_W     = 8;
  localparam int FRAME_TAIL = DATA_W + 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_HOLD  = 2'd2
  } rx_state_e;

  localparam logic [DATA_W-1:0] ERR_CODE = '1;

  function automatic logic parity_ok(input logic [DATA_W:0] v);
    return ^v;
  endfunction
endpackage

// File: rtl/kbd_sync_chain.sv
module kbd_sync_chain #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stg_d;
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = din;
      end else begin : g_rest
        assign stg_d[s] = stg_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/kbd_frame_shift.sv
module kbd_frame_shift
  import kbd_rx_pkg::*;
#(
  parameter int NBITS = FRAME_TAIL
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [NBITS-1:0] frame_d,
  output logic             last
);
  localparam int CNT_W = $clog2(NBITS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NBITS-1:0] sh_q, sh_d;

  // new bit enters at the top; after NBITS shifts the first bit sits at 0
  assign frame_d = {bit_in, sh_q[NBITS-1:1]};
  assign last    = shift_en && (cnt_q == CNT_W'(NBITS - 1));

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (clear) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (shift_en) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = frame_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end
endmodule

// File: rtl/kbd_rx_timer.sv
module kbd_rx_timer #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == CNT_W'(LIMIT));

  always_comb begin
    if (!run)         cnt_d = '0;
    else if (expired) cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/kbd_rx_engine.sv
module kbd_rx_engine
  import kbd_rx_pkg::*;
#(
  parameter int MS_CYCLES   = 50000,
  parameter int FRAME_MS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kbd_clk_i,
  input  logic              kbd_dat_i,
  output logic              kbd_clk_oe,
  input  logic              buf_take,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              err_parity,
  output logic              err_timeout,
  output logic              resend_req
);
  localparam int TMO_LIMIT = MS_CYCLES * FRAME_MS;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // line synchronizers and falling-edge detect
  logic [1:0] lines_s;
  logic       clk_s, dat_s, clk_prev_q, fall;

  kbd_sync_chain #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int_n),
    .din  ({kbd_dat_i, kbd_clk_i}),
    .dout (lines_s)
  );

  assign clk_s = lines_s[0];
  assign dat_s = lines_s[1];

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) clk_prev_q <= 1'b1;
    else            clk_prev_q <= clk_s;
  end
  assign fall = clk_prev_q & ~clk_s;

  // state
  rx_state_e         state_q, state_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] byte_q, byte_d;
  logic              perr_q, perr_d;
  logic              tmo_q, tmo_d;
  logic              retry_q, retry_d;
  logic              resend_q, resend_d;

  // frame shifter and timer
  logic [FRAME_TAIL-1:0] frame_d;
  logic                  frame_last, shift_en, tmr_exp, in_shift;
  logic [DATA_W-1:0]     f_data;
  logic                  f_par, f_stop;

  assign in_shift = (state_q == RX_SHIFT);
  assign shift_en = fall && in_shift;

  kbd_frame_shift #(
    .NBITS(FRAME_TAIL)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clear   (!in_shift),
    .shift_en(shift_en),
    .bit_in  (dat_s),
    .frame_d (frame_d),
    .last    (frame_last)
  );

  kbd_rx_timer #(
    .LIMIT(TMO_LIMIT)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run    (in_shift),
    .expired(tmr_exp)
  );

  assign f_data = frame_d[DATA_W-1:0];
  assign f_par  = frame_d[DATA_W];
  assign f_stop = frame_d[DATA_W+1];

  // next state
  always_comb begin
    state_d  = state_q;
    full_d   = full_q;
    byte_d   = byte_q;
    perr_d   = perr_q;
    tmo_d    = tmo_q;
    retry_d  = retry_q;
    resend_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (fall && !dat_s) state_d = RX_SHIFT;
      end
      RX_SHIFT: begin
        if (tmr_exp) begin
          state_d = RX_HOLD;
          full_d  = 1'b1;
          byte_d  = ERR_CODE;
          perr_d  = 1'b0;
          tmo_d   = 1'b1;
          retry_d = 1'b0;
        end else if (frame_last) begin
          if (!f_stop) begin
            state_d = RX_HOLD;
            full_d  = 1'b1;
            byte_d  = ERR_CODE;
            perr_d  = 1'b0;
            tmo_d   = 1'b1;
            retry_d = 1'b0;
          end else if (!parity_ok({f_par, f_data})) begin
            if (!retry_q) begin
              state_d  = RX_IDLE;
              retry_d  = 1'b1;
              resend_d = 1'b1;
            end else begin
              state_d = RX_HOLD;
              full_d  = 1'b1;
              byte_d  = ERR_CODE;
              perr_d  = 1'b1;
              tmo_d   = 1'b0;
              retry_d = 1'b0;
            end
          end else begin
            state_d = RX_HOLD;
            full_d  = 1'b1;
            byte_d  = f_data;
            perr_d  = 1'b0;
            tmo_d   = 1'b0;
            retry_d = 1'b0;
          end
        end
      end
      RX_HOLD: begin
        if (buf_take) begin
          state_d = RX_IDLE;
          full_d  = 1'b0;
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q  <= RX_IDLE;
      full_q   <= 1'b0;
      byte_q   <= '0;
      perr_q   <= 1'b0;
      tmo_q    <= 1'b0;
      retry_q  <= 1'b0;
      resend_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      full_q   <= full_d;
      byte_q   <= byte_d;
      perr_q   <= perr_d;
      tmo_q    <= tmo_d;
      retry_q  <= retry_d;
      resend_q <= resend_d;
    end
  end

  assign kbd_clk_oe  = (state_q == RX_HOLD);
  assign rx_valid    = full_q;
  assign rx_byte     = byte_q;
  assign err_parity  = perr_q;
  assign err_timeout = tmo_q;
  assign resend_req  = resend_q;

  // checks on the guarded logic
  a_r3_full_holds_clock: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid |-> kbd_clk_oe);

  a_r3_take_releases: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_valid && buf_take) |=> (!rx_valid && !kbd_clk_oe));

  a_r4_resend_single_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    resend_req |=> !resend_req);

  a_r5_retry_armed_after_resend: assert property (@(posedge clk) disable iff (!rst_int_n)
    resend_req |-> (retry_q && state_q == RX_IDLE));

  a_r6_err_code_on_error: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_valid && (err_parity || err_timeout)) |-> (rx_byte == ERR_CODE));

  a_r6_timeout_leaves_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    tmr_exp |=> (state_q != RX_SHIFT));

  a_r8_no_start_on_high_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state_q == RX_IDLE && fall && dat_s) |=> (state_q == RX_IDLE));
endmodule

// File: tb/sim_kbd_rx_engine.sv
`timescale 1ns/1ps
module sim_kbd_rx_engine;
  localparam int MSC  = 100;
  localparam int FMS  = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kbd_clk = 1'b1;
  logic       kbd_dat = 1'b1;
  logic       buf_take = 1'b0;
  logic       kbd_clk_oe;
  logic [7:0] rx_byte;
  logic       rx_valid, err_parity, err_timeout, resend_req;

  int n_chk = 0;
  int n_fail = 0;
  int resend_cnt = 0;

  always #10 clk = ~clk;

  kbd_rx_engine #(.MS_CYCLES(MSC), .FRAME_MS(FMS), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .kbd_clk_i(kbd_clk), .kbd_dat_i(kbd_dat),
    .kbd_clk_oe(kbd_clk_oe), .buf_take(buf_take), .rx_byte(rx_byte),
    .rx_valid(rx_valid), .err_parity(err_parity), .err_timeout(err_timeout),
    .resend_req(resend_req)
  );

  always @(negedge clk) if (rst_n && resend_req) resend_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic kb_bit(input logic b);
    @(negedge clk) kbd_dat = b;
    repeat (3) @(negedge clk);
    kbd_clk = 1'b0;
    repeat (3) @(negedge clk);
    kbd_clk = 1'b1;
  endtask

  task automatic send_frame(input logic [7:0] d, input logic par, input logic stp, input bit lat);
    kb_bit(1'b0);
    for (int i = 0; i < 8; i++) kb_bit(d[i]);
    kb_bit(par);
    @(negedge clk) kbd_dat = stp;
    repeat (3) @(negedge clk);
    kbd_clk = 1'b0;
    repeat (2) @(negedge clk);
    if (lat) chk(rx_valid == 1'b0, "R9 early", int'(rx_valid), 0);
    @(negedge clk);
    if (lat) chk(rx_valid == 1'b1, "R9 due", int'(rx_valid), 1);
    repeat (3) @(negedge clk);
    kbd_clk = 1'b1;
    repeat (4) @(negedge clk);
    kbd_dat = 1'b1;
  endtask

  task automatic take_byte();
    @(negedge clk) buf_take = 1'b1;
    @(negedge clk) buf_take = 1'b0;
    chk(rx_valid == 1'b0, "R3 valid after take", int'(rx_valid), 0);
    chk(kbd_clk_oe == 1'b0, "R3 clock released", int'(kbd_clk_oe), 0);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_up();
  end

  initial begin
    int rc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(rx_valid == 0, "R1 rx_valid", int'(rx_valid), 0);
    chk(kbd_clk_oe == 0, "R1 kbd_clk_oe", int'(kbd_clk_oe), 0);
    chk(err_parity == 0, "R1 err_parity", int'(err_parity), 0);
    chk(err_timeout == 0, "R1 err_timeout", int'(err_timeout), 0);
    chk(resend_cnt == 0, "R1 resend_req", resend_cnt, 0);

    // R2, R3, R9: every byte value with correct odd parity
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      send_frame(b, ~^b, 1'b1, 1'b1);
      chk(rx_byte == b, "R2 byte", int'(rx_byte), int'(b));
      chk(err_parity == 0 && err_timeout == 0, "R2 flags",
          int'({err_parity, err_timeout}), 0);
      chk(kbd_clk_oe == 1'b1, "R3 clock held", int'(kbd_clk_oe), 1);
      take_byte();
    end

    // R4: one bad parity, then good repeat
    rc = resend_cnt;
    send_frame(8'h3C, ^8'h3C, 1'b1, 1'b0);
    chk(resend_cnt == rc + 1, "R4 resend pulse", resend_cnt - rc, 1);
    chk(rx_valid == 0, "R4 no delivery", int'(rx_valid), 0);
    send_frame(8'h3C, ~^8'h3C, 1'b1, 1'b1);
    chk(rx_byte == 8'h3C && err_parity == 0, "R4 retry byte", int'(rx_byte), 'h3C);
    take_byte();

    // R5: two bad in a row
    rc = resend_cnt;
    send_frame(8'hA5, ^8'hA5, 1'b1, 1'b0);
    send_frame(8'hA5, ^8'hA5, 1'b1, 1'b1);
    chk(resend_cnt == rc + 1, "R5 one resend only", resend_cnt - rc, 1);
    chk(rx_byte == 8'hFF, "R5 code", int'(rx_byte), 'hFF);
    chk(err_parity == 1 && err_timeout == 0, "R5 flags",
        int'({err_parity, err_timeout}), 2);
    take_byte();

    // R10: clean byte clears flags
    send_frame(8'h12, ~^8'h12, 1'b1, 1'b1);
    chk(err_parity == 0 && rx_byte == 8'h12, "R10 parity flag clear", int'(err_parity), 0);
    take_byte();

    // R6: truncated character
    kb_bit(1'b0);
    kb_bit(1'b1);
    kb_bit(1'b0);
    kb_bit(1'b1);
    repeat (MSC * FMS + 50) @(negedge clk);
    chk(rx_valid == 1, "R6 delivered", int'(rx_valid), 1);
    chk(rx_byte == 8'hFF, "R6 code", int'(rx_byte), 'hFF);
    chk(err_timeout == 1 && err_parity == 0, "R6 flags",
        int'({err_parity, err_timeout}), 1);
    take_byte();

    // R7: low stop bit
    send_frame(8'h5A, ~^8'h5A, 1'b0, 1'b1);
    chk(rx_byte == 8'hFF, "R7 code", int'(rx_byte), 'hFF);
    chk(err_timeout == 1, "R7 flag", int'(err_timeout), 1);
    take_byte();

    // R10: timeout flag cleared
    send_frame(8'h81, ~^8'h81, 1'b1, 1'b1);
    chk(err_timeout == 0 && rx_byte == 8'h81, "R10 timeout flag clear", int'(err_timeout), 0);
    take_byte();

    // R8: take while empty, and a falling edge with data high
    @(negedge clk) buf_take = 1'b1;
    @(negedge clk) buf_take = 1'b0;
    repeat (3) @(negedge clk);
    chk(rx_valid == 0 && kbd_clk_oe == 0, "R8 empty take",
        int'({rx_valid, kbd_clk_oe}), 0);
    kb_bit(1'b1);
    repeat (4) @(negedge clk);
    chk(rx_valid == 0, "R8 high data ignored", int'(rx_valid), 0);
    send_frame(8'hC3, ~^8'hC3, 1'b1, 1'b1);
    chk(rx_byte == 8'hC3, "R8 framing intact", int'(rx_byte), 'hC3);
    take_byte();

    finish_up();
  end
endmodule